// File: doc/BRIEF.md
# Two-Coil Sine/Cosine Stepper PWM Output Stage

This block drives one two-coil stepper channel. Each coil side has its own compare value. The sine side is compared against timer count 0 and the cosine side against timer count 1. Each side gives a PWM level, and the block steers the two levels onto four drive pins: sine positive, sine negative, cosine positive and cosine negative. Steering follows one of two modes. In quadrant mode a two-bit field picks one pin per side, and the other two pins are held low. In all-pins mode each side's level drives both of that side's pins.

Each compare value has two registers. Software writes a master register. The PWM compares against a slave register. A transfer-enable flag in the 8-bit control register allows master-to-slave copies. While the flag is set, an overflow of timer 0 copies the sine master and an overflow of timer 1 copies the cosine master. The hardware clears the flag at the first overflow of either timer, so software can poll it to see that the commit has happened. Per-side options stretch the high time of the PWM by one count.

Top module: `stp_pwm_stage`

## Requirements
- R1: After synchronous reset the control register reads 0x00, both slave compare values are 0, and all four pins are low.
- R2: The control layout is as follows. Bit 7 selects all-pins mode. Bit 4 is transfer enable. Bit 3 enables the cosine add-one and bit 2 the sine add-one. Bits 1:0 hold the quadrant. Bits 6 and 5 ignore writes and read as 0, so writing 0xFF reads back 0x9F.
- R3: The sine PWM level is high while timer count 0 is below the sine slave value. The cosine PWM level is high while timer count 1 is below the cosine slave value.
- R4: With bit 2 set, the sine level is also high when count 0 equals the sine slave value. Bit 3 does the same for the cosine side, so the high time grows by one count.
- R5: In quadrant mode (bit 7 = 0) the routing is: 00 drives sine+ and cosine+, 01 drives sine+ and cosine−, 10 drives sine− and cosine−, 11 drives sine− and cosine+. The two unselected pins are low.
- R6: In all-pins mode (bit 7 = 1) the sine level drives both sine pins and the cosine level drives both cosine pins, whatever bits 1:0 hold.
- R7: While transfer enable is 0, master writes and timer overflows leave the slave values unchanged.
- R8: While transfer enable is 1, a timer 0 overflow copies the sine master to the sine slave, and a timer 1 overflow copies the cosine master to the cosine slave. Overflows of both timers in the same cycle copy both sides.
- R9: The hardware clears transfer enable at the first rising edge where either timer overflows. A later overflow then copies nothing.
- R10: A control write in the same cycle as a clearing overflow wins. The register takes the written value, including bit 4.
- R11: The pins are registered. A control write captured at one rising edge shows on the pins from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 8 | Control register write data |
| ctrl_rd_data | output | 8 | Control register read value |
| sin_cmp_wr_en | input | 1 | Write strobe for sine master compare |
| cos_cmp_wr_en | input | 1 | Write strobe for cosine master compare |
| cmp_wr_data | input | CNT_W | Master compare write data |
| tmr0_cnt | input | CNT_W | Free-running count for the sine side |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_cnt | input | CNT_W | Free-running count for the cosine side |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| pin_sin_pos | output | 1 | Sine positive drive pin |
| pin_sin_neg | output | 1 | Sine negative drive pin |
| pin_cos_pos | output | 1 | Cosine positive drive pin |
| pin_cos_neg | output | 1 | Cosine negative drive pin |

## Verification
Suppose a slave value is copied at the wrong time, or is never copied. The pins then show a duty that belongs to the wrong compare value, one clock after the count is applied. Suppose instead the transfer flag fails to clear. The read port shows this at the cycle after the overflow, and the next overflow of the other timer makes a second, unwanted copy, which also appears on the pins. A routing or quadrant decode fault shows on the pins one clock after the control write. It appears either as a wrong pin driven, or as both pins of a side high in quadrant mode.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef enum logic [1:0] {
        QUAD_1 = 2'd0,
        QUAD_2 = 2'd1,
        QUAD_3 = 2'd2,
        QUAD_4 = 2'd3
    } quad_e;

    typedef struct packed {
        logic       all_pins;
        logic [1:0] rsvd;
        logic       xfer_en;
        logic       cos_add;
        logic       sin_add;
        quad_e      quad;
    } ctrl_t;

    typedef struct packed {
        logic sin_pos;
        logic sin_neg;
        logic cos_pos;
        logic cos_neg;
    } pins_t;

    localparam int N_SIDES  = 2;
    localparam int SIDE_SIN = 0;
    localparam int SIDE_COS = 1;

    // Writable bits of the control register; bits 6 and 5 stay zero.
    localparam logic [7:0] CTRL_WR_MASK = 8'h9F;

    function automatic pins_t route_pins(logic all_pins, quad_e q,
                                         logic s_lvl, logic c_lvl);
        pins_t p;
        p = '0;
        if (all_pins) begin
            p.sin_pos = s_lvl;
            p.sin_neg = s_lvl;
            p.cos_pos = c_lvl;
            p.cos_neg = c_lvl;
        end else begin
            case (q)
                QUAD_1: begin p.sin_pos = s_lvl; p.cos_pos = c_lvl; end
                QUAD_2: begin p.sin_pos = s_lvl; p.cos_neg = c_lvl; end
                QUAD_3: begin p.sin_neg = s_lvl; p.cos_neg = c_lvl; end
                default: begin p.sin_neg = s_lvl; p.cos_pos = c_lvl; end
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/stp_ctrl_reg.sv
module stp_ctrl_reg
    import stp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       any_ovf,
    output ctrl_t      ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wr_data & CTRL_WR_MASK);
        end else if (any_ovf && ctrl_q.xfer_en) begin
            ctrl_q.xfer_en <= 1'b0;
        end
    end

    // R9
    ten_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && any_ovf && ctrl_q.xfer_en) |=> !ctrl_q.xfer_en);

    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_q == ctrl_t'($past(wr_data) & CTRL_WR_MASK)));

endmodule

// File: rtl/stp_cmp_buf.sv
module stp_cmp_buf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         xfer_en,
    input  logic         ovf,
    output logic [W-1:0] slave_q
);

    logic [W-1:0] master_q;
    logic         commit;

    assign commit = xfer_en && ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= '0;
        end else if (wr_en) begin
            master_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slave_q <= '0;
        end else if (commit) begin
            slave_q <= master_q;
        end
    end

    // R8
    copy_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && ovf) |=> (slave_q == $past(master_q)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(xfer_en && ovf) |=> $stable(slave_q));

endmodule

// File: rtl/stp_pwm_gen.sv
module stp_pwm_gen #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         add_one,
    output logic         level
);

    always_comb begin
        if (add_one) begin
            level = (cnt <= cmp);
        end else begin
            level = (cnt < cmp);
        end
    end

endmodule

// File: rtl/stp_pin_router.sv
module stp_pin_router
    import stp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  all_pins,
    input  quad_e quad,
    input  logic  sin_lvl,
    input  logic  cos_lvl,
    output pins_t pins_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= '0;
        end else begin
            pins_q <= route_pins(all_pins, quad, sin_lvl, cos_lvl);
        end
    end

    // R6
    allpin_pair_chk: assert property (@(posedge clk) disable iff (rst)
        all_pins |=> (pins_q.sin_pos == pins_q.sin_neg) &&
                     (pins_q.cos_pos == pins_q.cos_neg));

    // R5
    quad_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !all_pins |=> !(pins_q.sin_pos && pins_q.sin_neg) &&
                      !(pins_q.cos_pos && pins_q.cos_neg));

    // R3
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!sin_lvl && !cos_lvl) |=> ($countones(pins_q) == 0));

endmodule

// File: rtl/stp_pwm_stage.sv
module stp_pwm_stage
    import stp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr_en,
    input  logic [7:0]       ctrl_wr_data,
    output logic [7:0]       ctrl_rd_data,
    input  logic             sin_cmp_wr_en,
    input  logic             cos_cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic [CNT_W-1:0] tmr0_cnt,
    input  logic             tmr0_ovf,
    input  logic [CNT_W-1:0] tmr1_cnt,
    input  logic             tmr1_ovf,
    output logic             pin_sin_pos,
    output logic             pin_sin_neg,
    output logic             pin_cos_pos,
    output logic             pin_cos_neg
);

    ctrl_t            ctrl_q;
    pins_t            pins_q;
    logic             any_ovf;
    logic [CNT_W-1:0] cnt_s   [N_SIDES];
    logic [CNT_W-1:0] slave_s [N_SIDES];
    logic             ovf_s   [N_SIDES];
    logic             we_s    [N_SIDES];
    logic             add_s   [N_SIDES];
    logic             lvl_s   [N_SIDES];

    assign any_ovf = tmr0_ovf | tmr1_ovf;

    assign cnt_s[SIDE_SIN] = tmr0_cnt;
    assign cnt_s[SIDE_COS] = tmr1_cnt;
    assign ovf_s[SIDE_SIN] = tmr0_ovf;
    assign ovf_s[SIDE_COS] = tmr1_ovf;
    assign we_s[SIDE_SIN]  = sin_cmp_wr_en;
    assign we_s[SIDE_COS]  = cos_cmp_wr_en;
    assign add_s[SIDE_SIN] = ctrl_q.sin_add;
    assign add_s[SIDE_COS] = ctrl_q.cos_add;

    stp_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr_en),
        .wr_data (ctrl_wr_data),
        .any_ovf (any_ovf),
        .ctrl_q  (ctrl_q)
    );

    for (genvar i = 0; i < N_SIDES; i++) begin : g_side
        stp_cmp_buf #(.W(CNT_W)) u_buf (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (we_s[i]),
            .wr_data (cmp_wr_data),
            .xfer_en (ctrl_q.xfer_en),
            .ovf     (ovf_s[i]),
            .slave_q (slave_s[i])
        );

        stp_pwm_gen #(.W(CNT_W)) u_pwm (
            .cnt     (cnt_s[i]),
            .cmp     (slave_s[i]),
            .add_one (add_s[i]),
            .level   (lvl_s[i])
        );
    end

    stp_pin_router u_route (
        .clk      (clk),
        .rst      (rst),
        .all_pins (ctrl_q.all_pins),
        .quad     (ctrl_q.quad),
        .sin_lvl  (lvl_s[SIDE_SIN]),
        .cos_lvl  (lvl_s[SIDE_COS]),
        .pins_q   (pins_q)
    );

    assign ctrl_rd_data = ctrl_q;
    assign pin_sin_pos  = pins_q.sin_pos;
    assign pin_sin_neg  = pins_q.sin_neg;
    assign pin_cos_pos  = pins_q.cos_pos;
    assign pin_cos_neg  = pins_q.cos_neg;

endmodule

// File: tb/stp_pwm_stage_tb.sv
`timescale 1ns/1ps
module stp_pwm_stage_tb;

    localparam int W = 16;

    typedef struct packed {
        logic [7:0]   ctrl;
        logic [W-1:0] sv;
        logic [W-1:0] cv;
        logic [W-1:0] c0;
        logic [W-1:0] c1;
        logic [3:0]   exp;   // {sin+, sin-, cos+, cos-}
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 16'd100, 16'd50, 16'd10,  16'd10, 4'b1010},  // R5 quadrant 00
        '{8'h01, 16'd100, 16'd50, 16'd10,  16'd10, 4'b1001},  // R5 quadrant 01
        '{8'h02, 16'd100, 16'd50, 16'd10,  16'd10, 4'b0101},  // R5 quadrant 10
        '{8'h03, 16'd100, 16'd50, 16'd10,  16'd10, 4'b0110},  // R5 quadrant 11
        '{8'h80, 16'd100, 16'd50, 16'd10,  16'd10, 4'b1111},  // R6 all pins
        '{8'h80, 16'd100, 16'd50, 16'd200, 16'd10, 4'b0011},  // R3 sine past compare
        '{8'h00, 16'd100, 16'd50, 16'd100, 16'd50, 4'b0000},  // R3 equal, no add
        '{8'h04, 16'd100, 16'd50, 16'd100, 16'd50, 4'b1000},  // R4 sine add-one
        '{8'h08, 16'd100, 16'd50, 16'd100, 16'd50, 4'b0010},  // R4 cosine add-one
        '{8'h8C, 16'd100, 16'd50, 16'd100, 16'd50, 4'b1111},  // R4 both, all pins
        '{8'h83, 16'd100, 16'd50, 16'd0,   16'd60, 4'b1100},  // R6 quadrant ignored
        '{8'h0E, 16'd0,   16'd0,  16'd0,   16'd0,  4'b0101}   // R4 zero compare + add
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         ctrl_wr_en;
    logic [7:0]   ctrl_wr_data;
    logic [7:0]   ctrl_rd_data;
    logic         sin_cmp_wr_en;
    logic         cos_cmp_wr_en;
    logic [W-1:0] cmp_wr_data;
    logic [W-1:0] tmr0_cnt;
    logic         tmr0_ovf;
    logic [W-1:0] tmr1_cnt;
    logic         tmr1_ovf;
    logic         pin_sin_pos, pin_sin_neg, pin_cos_pos, pin_cos_neg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    stp_pwm_stage #(.CNT_W(W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .ctrl_wr_en    (ctrl_wr_en),
        .ctrl_wr_data  (ctrl_wr_data),
        .ctrl_rd_data  (ctrl_rd_data),
        .sin_cmp_wr_en (sin_cmp_wr_en),
        .cos_cmp_wr_en (cos_cmp_wr_en),
        .cmp_wr_data   (cmp_wr_data),
        .tmr0_cnt      (tmr0_cnt),
        .tmr0_ovf      (tmr0_ovf),
        .tmr1_cnt      (tmr1_cnt),
        .tmr1_ovf      (tmr1_ovf),
        .pin_sin_pos   (pin_sin_pos),
        .pin_sin_neg   (pin_sin_neg),
        .pin_cos_pos   (pin_cos_pos),
        .pin_cos_neg   (pin_cos_neg)
    );

    function automatic logic [3:0] pins();
        return {pin_sin_pos, pin_sin_neg, pin_cos_pos, pin_cos_neg};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        @(negedge clk);
        ctrl_wr_en   = 1'b1;
        ctrl_wr_data = d;
        @(negedge clk);
        ctrl_wr_en   = 1'b0;
    endtask

    task automatic wr_sin(logic [W-1:0] d);
        @(negedge clk);
        sin_cmp_wr_en = 1'b1;
        cmp_wr_data   = d;
        @(negedge clk);
        sin_cmp_wr_en = 1'b0;
    endtask

    task automatic wr_cos(logic [W-1:0] d);
        @(negedge clk);
        cos_cmp_wr_en = 1'b1;
        cmp_wr_data   = d;
        @(negedge clk);
        cos_cmp_wr_en = 1'b0;
    endtask

    task automatic pulse_ovf(logic o0, logic o1);
        @(negedge clk);
        tmr0_ovf = o0;
        tmr1_ovf = o1;
        @(negedge clk);
        tmr0_ovf = 1'b0;
        tmr1_ovf = 1'b0;
    endtask

    task automatic load_slaves(logic [W-1:0] sv, logic [W-1:0] cv);
        wr_sin(sv);
        wr_cos(cv);
        wr_ctrl(8'h10);
        pulse_ovf(1'b1, 1'b1);
    endtask

    // Apply counts and control, then sample after two rising edges.
    task automatic apply(logic [7:0] c, logic [W-1:0] n0, logic [W-1:0] n1);
        @(negedge clk);
        tmr0_cnt     = n0;
        tmr1_cnt     = n1;
        ctrl_wr_en   = 1'b1;
        ctrl_wr_data = c;
        @(negedge clk);
        ctrl_wr_en   = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        ctrl_wr_en = 1'b0; ctrl_wr_data = '0;
        sin_cmp_wr_en = 1'b0; cos_cmp_wr_en = 1'b0; cmp_wr_data = '0;
        tmr0_cnt = '0; tmr1_cnt = '0; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 ctrl after reset", 32'(ctrl_rd_data), 32'h00);
        check("R1 pins after reset", 32'(pins()), 32'h0);
        apply(8'h80, '0, '0);
        check("R1 slaves zero at reset", 32'(pins()), 32'h0);

        // R2 reserved bits
        wr_ctrl(8'hFF);
        check("R2 readback of 0xFF", 32'(ctrl_rd_data), 32'h9F);
        wr_ctrl(8'h00);
        check("R2 readback of 0x00", 32'(ctrl_rd_data), 32'h00);

        // Vector table: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            load_slaves(VEC[i].sv, VEC[i].cv);
            apply(VEC[i].ctrl, VEC[i].c0, VEC[i].c1);
            check($sformatf("R3/R4/R5/R6 vector %0d", i),
                  32'(pins()), 32'(VEC[i].exp));
        end

        // R7: transfer disabled, master write and overflow do not commit
        load_slaves(16'd100, 16'd100);
        wr_sin(16'd200);
        pulse_ovf(1'b1, 1'b1);
        apply(8'h80, 16'd150, 16'd0);
        check("R7 slave held without transfer", 32'(pins()), 32'b0011);

        // R8 cosine-only commit on timer 1, R9 flag clears
        wr_cos(16'd0);
        wr_ctrl(8'h90);
        pulse_ovf(1'b0, 1'b1);
        check("R9 flag cleared by overflow", 32'(ctrl_rd_data), 32'h80);
        apply(8'h80, 16'd150, 16'd0);
        check("R8 cosine copied on timer 1", 32'(pins()), 32'b0000);
        apply(8'h80, 16'd150, 16'd150);
        check("R8 sine not copied on timer 1", 32'(pins()), 32'b0000);
        apply(8'h80, 16'd50, 16'd0);
        check("R8 sine slave still old value", 32'(pins()), 32'b1100);
        pulse_ovf(1'b1, 1'b0);
        apply(8'h80, 16'd150, 16'd0);
        check("R9 no copy after flag cleared", 32'(pins()), 32'b0000);

        // R10 write wins over clearing overflow
        wr_ctrl(8'h10);
        @(negedge clk);
        ctrl_wr_en = 1'b1; ctrl_wr_data = 8'h10; tmr0_ovf = 1'b1;
        @(negedge clk);
        ctrl_wr_en = 1'b0; tmr0_ovf = 1'b0;
        check("R10 write beats overflow clear", 32'(ctrl_rd_data), 32'h10);
        apply(8'h80, 16'd150, 16'd0);
        check("R8 sine copied on timer 0", 32'(pins()), 32'b1100);

        // R11 pin timing after a quadrant change
        load_slaves(16'd100, 16'd100);
        apply(8'h00, 16'd10, 16'd10);
        check("R11 quadrant 00 baseline", 32'(pins()), 32'b1010);
        @(negedge clk);
        ctrl_wr_en = 1'b1; ctrl_wr_data = 8'h02;
        @(negedge clk);
        ctrl_wr_en = 1'b0;
        check("R11 pins unchanged at capture edge", 32'(pins()), 32'b1010);
        @(negedge clk);
        check("R11 pins follow on next edge", 32'(pins()), 32'b0101);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule